// File: doc/BRIEF.md
# Power-On Configuration Strap Latch

This block reads board-level configuration straps from six pins that later serve as a voltage-identification output bus. It watches an external termination-rail power-good signal and a vector of internal power-good flags. Both kinds of input are synchronized into the block clock domain. On the first cycle where every synchronized power-good is true, the block records the pin levels. It then splits them into a package-identifier field and a core-select field.

The recorded fields stay frozen until the next reset. Any reset is treated the same way, whether warm or cold: it clears the fields and arms sampling again. When capture happens, a valid flag rises. A drive-enable output also rises, which tells the pad logic that the pins now belong to the voltage-identification function. A self-test request does not arrive on these pins, so the block neither samples nor exposes one.

Top module: `strap_capture_top`

## Requirements
- R1: While `rst` is high and on the cycle after it, `cfg_valid` and `vid_drive_en` are 0, and `pkg_id` and `core_sel` are all zeros.
- R2: No capture occurs unless `ext_pwr_good` and every bit of `int_pwr_good` are high together. With any one of these low, `cfg_valid` stays 0.
- R3: At capture, `pkg_id` takes the value of `strap_pins[2:0]`.
- R4: At capture, `core_sel` takes the value of `strap_pins[5:3]`.
- R5: Suppose all power-good inputs become high together and are first seen by rising clock edge k. Then `cfg_valid` is 0 after edge k+1 and 1 after edge k+2. The pins are sampled at edge k+2.
- R6: After capture, changes on `strap_pins` have no effect on `pkg_id` or `core_sel`.
- R7: After capture, if power-good drops and later rises again with no reset in between, the fields are not changed and `cfg_valid` stays 1.
- R8: Any reset clears the captured state and re-arms sampling. If power-good is held high through a reset, a new capture takes place once reset is released, following the R5 timing.
- R9: `vid_drive_en` rises in the same cycle as `cfg_valid`. It stays high until reset, and it is never high while `cfg_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset, either warm or cold |
| strap_pins | input | 6 | Shared strap / voltage-identification pin levels |
| ext_pwr_good | input | 1 | External termination-rail power-good, asynchronous |
| int_pwr_good | input | N_IPG | Internal power-good flags, asynchronous |
| pkg_id | output | 3 | Latched package-identifier field |
| core_sel | output | 3 | Latched core-select field |
| cfg_valid | output | 1 | Fields have been captured |
| vid_drive_en | output | 1 | Pins are handed over to voltage-identification use |

## Verification
All 64 strap patterns are captured one after another. Each one separates the two fields bit by bit, so a swapped or shifted pin slice shows up. Every combination of power-good inputs except all-high is held for many cycles, which shows whether any single flag is wrongly left out of the qualifying AND. After each capture, the pins are inverted, and power-good is dropped and raised again. Comparing these cases tells the frozen behaviour apart from re-triggering on a later edge. A reset with power-good held high shows that warm and cold resets re-arm in the same way.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int PKG_W  = 3;
    localparam int CORE_W = 3;
    localparam int PIN_W  = PKG_W + CORE_W;

    typedef struct packed {
        logic [CORE_W-1:0] core_sel;
        logic [PKG_W-1:0]  pkg_id;
    } strap_word_t;

    localparam strap_word_t STRAP_CLEAR = '{core_sel: '0, pkg_id: '0};

    function automatic strap_word_t strap_split(input logic [PIN_W-1:0] pins);
        strap_word_t w;
        w.pkg_id   = pins[PKG_W-1:0];
        w.core_sel = pins[PIN_W-1:PKG_W];
        return w;
    endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= async_in;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/pg_qualify.sv
module pg_qualify #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] synced,
    output logic         rise
);
    logic all_good;
    logic all_good_q;

    assign all_good = &synced;

    always_ff @(posedge clk) begin
        if (rst) all_good_q <= 1'b0;
        else     all_good_q <= all_good;
    end

    assign rise = all_good & ~all_good_q;
endmodule

// File: rtl/strap_hold.sv
module strap_hold
    import strap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic [PIN_W-1:0] pins,
    output strap_word_t      word,
    output logic             valid,
    output logic             drive_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word     <= STRAP_CLEAR;
            valid    <= 1'b0;
            drive_en <= 1'b0;
        end else if (rise && !valid) begin
            word     <= strap_split(pins);
            valid    <= 1'b1;
            drive_en <= 1'b1;
        end
    end
endmodule

// File: rtl/strap_capture_top.sv
module strap_capture_top
    import strap_pkg::*;
#(
    parameter int N_IPG       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIN_W-1:0]  strap_pins,
    input  logic              ext_pwr_good,
    input  logic [N_IPG-1:0]  int_pwr_good,
    output logic [PKG_W-1:0]  pkg_id,
    output logic [CORE_W-1:0] core_sel,
    output logic              cfg_valid,
    output logic              vid_drive_en
);
    localparam int PG_W = N_IPG + 1;

    logic [PG_W-1:0] pg_raw;
    logic [PG_W-1:0] pg_synced;
    logic            pg_rise;
    strap_word_t     held;

    assign pg_raw = {int_pwr_good, ext_pwr_good};

    pg_sync #(.W(PG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(pg_raw), .sync_out(pg_synced)
    );

    pg_qualify #(.W(PG_W)) u_qual (
        .clk(clk), .rst(rst), .synced(pg_synced), .rise(pg_rise)
    );

    strap_hold u_hold (
        .clk(clk), .rst(rst), .rise(pg_rise), .pins(strap_pins),
        .word(held), .valid(cfg_valid), .drive_en(vid_drive_en)
    );

    assign pkg_id   = held.pkg_id;
    assign core_sel = held.core_sel;
endmodule

// File: rtl/strap_capture_chk.sv
module strap_capture_chk
    import strap_pkg::*;
#(
    parameter int N_IPG = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [PIN_W-1:0]  strap_pins,
    input logic              ext_pwr_good,
    input logic [N_IPG-1:0]  int_pwr_good,
    input logic [PKG_W-1:0]  pkg_id,
    input logic [CORE_W-1:0] core_sel,
    input logic              cfg_valid,
    input logic              vid_drive_en
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!cfg_valid && !vid_drive_en && pkg_id == '0 && core_sel == '0));

    a_r2_needs_all_good: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_valid) |-> ($past(ext_pwr_good, 3) && $past(&int_pwr_good, 3)));

    a_r3_pkg_field: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_valid) |-> (pkg_id == $past(strap_pins[PKG_W-1:0])));

    a_r4_core_field: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_valid) |-> (core_sel == $past(strap_pins[PIN_W-1:PKG_W])));

    a_r6_fields_frozen: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |=> (cfg_valid && $stable(pkg_id) && $stable(core_sel)));

    a_r9_drive_follows: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid |-> !vid_drive_en);

    a_r9_drive_sticky: assert property (@(posedge clk) disable iff (rst)
        vid_drive_en |=> vid_drive_en);
endmodule

bind strap_capture_top strap_capture_chk #(.N_IPG(N_IPG)) u_chk (
    .clk(clk), .rst(rst), .strap_pins(strap_pins), .ext_pwr_good(ext_pwr_good),
    .int_pwr_good(int_pwr_good), .pkg_id(pkg_id), .core_sel(core_sel),
    .cfg_valid(cfg_valid), .vid_drive_en(vid_drive_en)
);

// File: tb/sim_strap_capture_top.sv
module sim_strap_capture_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_IPG = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] strap_pins = '0;
    logic       ext_pwr_good = 1'b0;
    logic [N_IPG-1:0] int_pwr_good = '0;
    logic [2:0] pkg_id;
    logic [2:0] core_sel;
    logic       cfg_valid;
    logic       vid_drive_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_capture_top #(.N_IPG(N_IPG), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .strap_pins(strap_pins), .ext_pwr_good(ext_pwr_good),
        .int_pwr_good(int_pwr_good), .pkg_id(pkg_id), .core_sel(core_sel),
        .cfg_valid(cfg_valid), .vid_drive_en(vid_drive_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        edges(2);
        rst = 1'b0;
    endtask

    task automatic set_pg(input logic on);
        ext_pwr_good = on;
        int_pwr_good = on ? '1 : '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        edges(3);
        // R1: state during reset
        chk("R1 valid", int'(cfg_valid), 0);
        chk("R1 drive", int'(vid_drive_en), 0);
        chk("R1 fields", int'({core_sel, pkg_id}), 0);
        rst = 1'b0;

        // R2: every combination of power-good inputs except all-high
        for (int c = 0; c < (1 << (N_IPG + 1)) - 1; c++) begin
            do_reset();
            ext_pwr_good = c[0];
            int_pwr_good = N_IPG'(c >> 1);
            strap_pins = 6'h2A;
            edges(6);
            chk("R2 no capture", int'(cfg_valid), 0);
            chk("R2 no drive", int'(vid_drive_en), 0);
        end
        set_pg(1'b0);

        // Sweep through all strap patterns
        for (int p = 0; p < 64; p++) begin
            do_reset();
            chk("R1 after reset", int'({cfg_valid, vid_drive_en, core_sel, pkg_id}), 0);
            strap_pins = 6'(p);
            set_pg(1'b1);
            edges(2);
            chk("R5 still low", int'(cfg_valid), 0);
            edges(1);
            chk("R5 valid high", int'(cfg_valid), 1);
            chk("R9 drive with valid", int'(vid_drive_en), 1);
            chk("R3 pkg_id", int'(pkg_id), p & 7);
            chk("R4 core_sel", int'(core_sel), p >> 3);
            strap_pins = ~6'(p);
            edges(3);
            chk("R6 frozen", int'({core_sel, pkg_id}), p);
            set_pg(1'b0);
            edges(4);
            set_pg(1'b1);
            edges(5);
            chk("R7 retained", int'({core_sel, pkg_id}), p);
            chk("R7 valid kept", int'(cfg_valid), 1);
            chk("R9 drive kept", int'(vid_drive_en), 1);
        end

        // R8: warm reset while power-good is held high
        strap_pins = 6'h15;
        do_reset();
        chk("R8 cleared", int'({cfg_valid, core_sel, pkg_id}), 0);
        edges(2);
        chk("R8 not yet", int'(cfg_valid), 0);
        edges(1);
        chk("R8 recaptured", int'({cfg_valid, core_sel, pkg_id}), 64 + 6'h15);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule